// File: doc/BRIEF.md
# Processor Core Register Bank with Boot Loader

This block keeps the architectural register state of a 32-bit processor core. It holds thirteen general data registers, a stack pointer with two physical copies (main and process), a link register, a program counter, a status word, an interrupt mask bit and a two-bit control field. The datapath reaches the numbered registers 0 to 15 through two registered read ports and one write port. The status, mask and control registers have their own write strobes and always-visible outputs.

Reset puts a small boot sequencer in charge. It issues two word reads on a request/valid memory port. The word at address 0x0 becomes the main stack pointer, and the word at address 0x4 becomes the program entry address. Bit 0 of the entry word is the instruction-set state bit. If that bit is clear, a sticky fault flag is raised. The core may run only once `core_ready` rises.

Register 13 resolves to one of the two stack copies. In handler context, which is any nonzero exception number on `exc_num`, it always means the main copy. In thread context, control bit 1 chooses the process copy.

Top module: `core_regbank`

## Requirements
- R1: After synchronous reset, `mem_req` pulses for one cycle with `mem_addr`=0x0. The cycle after the matching `mem_rvalid`, it pulses again with `mem_addr`=0x4. `core_ready` is low until the second `mem_rvalid` has been taken and is high from the next cycle on.
- R2: The first boot word is stored as the main stack pointer with bits 1:0 cleared, and register 13 reads it after boot.
- R3: The second boot word is stored as the program counter (register 15) with bit 0 cleared, and its bit 0 is copied into status bit 24.
- R4: If bit 0 of the second boot word is 0, `vec_fault` goes high and stays high until the next reset; otherwise it stays low.
- R5: Registers 0-12 and 14 keep written values. Each read port returns, one clock after its index is presented, the contents from before any write in that same cycle.
- R6: Register 13 reads and writes the process copy only when `exc_num` is 0 and control bit 1 is 1; otherwise it uses the main copy.
- R7: Writes to register 13 clear bits 1:0, and writes to register 15 clear bit 0.
- R8: `psr_out` carries the flags written through `flags_in` in bits 31:28, the state bit in bit 24, and `exc_num` in bits 5:0; every other bit is 0.
- R9: `mask_out` keeps only bit 0 of `mask_in`, and `ctrl_out` keeps only bits 1:0 of `ctrl_in`. The remaining bits read 0, and both registers read 0 after reset.
- R10: All write strobes (`wr_en`, `flags_wr`, `mask_wr`, `ctrl_wr`) are ignored while `core_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Boot read request, one cycle per word |
| mem_addr | output | 32 | Boot read byte address |
| mem_rvalid | input | 1 | Read data valid, one cycle after a request |
| mem_rdata | input | 32 | Read data word |
| core_ready | output | 1 | Boot finished, core may execute |
| vec_fault | output | 1 | Entry word had bit 0 clear |
| exc_num | input | 6 | Current exception number, 0 = thread context |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data, one cycle latency |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data, one cycle latency |
| wr_en | input | 1 | Numbered register write strobe |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| flags_wr | input | 1 | Condition flag write strobe |
| flags_in | input | 4 | New N, Z, C, V flags |
| psr_out | output | 32 | Combined status word |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_in | input | 32 | Interrupt mask write data |
| mask_out | output | 32 | Interrupt mask register |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_in | input | 32 | Control write data |
| ctrl_out | output | 32 | Control register |

## Verification
The assertions assume that the memory answers every request with exactly one `mem_rvalid`, one cycle later, and never raises `mem_rvalid` unprompted. The bench memory model registers `mem_req` into `mem_rvalid` to meet that. The checks also assume that `exc_num` and the read indices change only between clock edges. The stimulus applies every input change a fixed delay after the rising edge, or at the falling edge, and never on the edge. Write strobes are held during the whole boot window, so the gating under R10 is exercised on every reset.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int XLEN      = 32;
  localparam int RIDX_W    = 4;
  localparam int NUM_GPR   = 13;
  localparam int IDX_SP    = 13;
  localparam int IDX_LR    = 14;
  localparam int IDX_PC    = 15;
  localparam int EXC_W     = 6;
  localparam int FLAG_W    = 4;
  localparam int PSR_T_POS = 24;
  localparam int PSR_F_LSB = 28;

  typedef enum logic [2:0] {
    BS_REQ_SP,
    BS_WAIT_SP,
    BS_REQ_PC,
    BS_WAIT_PC,
    BS_RUN
  } boot_state_t;
endpackage

// File: rtl/rb_boot_seq.sv
module rb_boot_seq
  import rb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int unsigned SP_ADDR  = 0,
  parameter int unsigned VEC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_sp,
  output logic              ld_pc,
  output logic [DATA_W-1:0] ld_word,
  output logic              ready
);
  boot_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BS_REQ_SP;
    end else begin
      case (state)
        BS_REQ_SP:  state <= BS_WAIT_SP;
        BS_WAIT_SP: if (mem_rvalid) state <= BS_REQ_PC;
        BS_REQ_PC:  state <= BS_WAIT_PC;
        BS_WAIT_PC: if (mem_rvalid) state <= BS_RUN;
        default:    state <= BS_RUN;
      endcase
    end
  end

  assign mem_req  = (state == BS_REQ_SP) || (state == BS_REQ_PC);
  assign mem_addr = (state == BS_REQ_PC) ? ADDR_W'(VEC_ADDR) : ADDR_W'(SP_ADDR);
  assign ld_sp    = (state == BS_WAIT_SP) && mem_rvalid;
  assign ld_pc    = (state == BS_WAIT_PC) && mem_rvalid;
  assign ld_word  = mem_rdata;
  assign ready    = (state == BS_RUN);

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R1
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R1
  AST_READY_AFTER_PC: assert property (@(posedge clk) disable iff (rst) $rose(ready) |-> $past(ld_pc)); // R1
endmodule

// File: rtl/rb_gpr_ram.sv
module rb_gpr_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/rb_sp_bank.sv
module rb_sp_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_psp,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boot_ld,
  input  logic [DATA_W-1:0] boot_data,
  output logic [DATA_W-1:0] sp_cur
);
  logic [DATA_W-1:0] msp_q, psp_q;
  logic              unused_lsbs;

  assign unused_lsbs = ^{wr_data[1:0], boot_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      msp_q <= '0;
      psp_q <= '0;
    end else if (boot_ld) begin
      msp_q <= {boot_data[DATA_W-1:2], 2'b00};
    end else if (wr_en) begin
      if (use_psp) psp_q <= {wr_data[DATA_W-1:2], 2'b00};
      else         msp_q <= {wr_data[DATA_W-1:2], 2'b00};
    end
  end

  assign sp_cur = use_psp ? psp_q : msp_q;

  AST_SP_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst) (msp_q[1:0] == 2'b00) && (psp_q[1:0] == 2'b00)); // R7
  AST_PSP_UNTOUCHED: assert property (@(posedge clk) disable iff (rst) (wr_en && !use_psp) |=> $stable(psp_q)); // R6
endmodule

// File: rtl/core_regbank.sv
module core_regbank
  import rb_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = RIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              core_ready,
  output logic              vec_fault,
  input  logic [EXC_W-1:0]  exc_num,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flags_wr,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] psr_out,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_in,
  output logic [DATA_W-1:0] mask_out,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_in,
  output logic [DATA_W-1:0] ctrl_out
);
  localparam int NPORT = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic              ld_sp, ld_pc;
  logic [DATA_W-1:0] ld_word;
  logic              ready;
  logic [DATA_W-1:0] pc_q, sp_cur;
  logic              t_q, fault_q, mask_q;
  logic [1:0]        ctrl_q;
  logic [FLAG_W-1:0] flags_q;
  logic              handler, use_psp, wr_ok, gpr_we, sp_we, pc_we;
  logic              unused_hi;

  assign unused_hi = ^{mask_in[DATA_W-1:1], ctrl_in[DATA_W-1:2]};

  rb_boot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_ADDR(0), .VEC_ADDR(4)) u_boot (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_sp(ld_sp), .ld_pc(ld_pc), .ld_word(ld_word), .ready(ready)
  );

  // Register 13 context select: handler context always uses the main copy.
  assign handler = |exc_num;
  assign use_psp = !handler && ctrl_q[1];
  assign wr_ok   = wr_en && ready;
  assign gpr_we  = wr_ok && ((wr_idx < IDX_W'(NUM_GPR)) || (wr_idx == IDX_W'(IDX_LR)));
  assign sp_we   = wr_ok && (wr_idx == IDX_W'(IDX_SP));
  assign pc_we   = wr_ok && (wr_idx == IDX_W'(IDX_PC));

  logic [NPORT-1:0][IDX_W-1:0]  rd_idx;
  logic [NPORT-1:0][DATA_W-1:0] ram_q, spec_q, rd_data;
  logic [NPORT-1:0]             spec_sel;

  assign rd_idx[0]  = rd_a_idx;
  assign rd_idx[1]  = rd_b_idx;
  assign rd_a_data  = rd_data[0];
  assign rd_b_data  = rd_data[1];

  rb_gpr_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_gpr (
    .clk(clk), .we(gpr_we), .waddr(wr_idx), .wdata(wr_data),
    .raddr_a(rd_idx[0]), .raddr_b(rd_idx[1]),
    .rdata_a(ram_q[0]), .rdata_b(ram_q[1])
  );

  rb_sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk(clk), .rst(rst), .use_psp(use_psp), .wr_en(sp_we), .wr_data(wr_data),
    .boot_ld(ld_sp), .boot_data(ld_word), .sp_cur(sp_cur)
  );

  // Special registers kept beside the RAM; read ports pick them after the RAM stage.
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_rport
      always_ff @(posedge clk) begin
        if (rst) begin
          spec_sel[p] <= 1'b0;
          spec_q[p]   <= '0;
        end else begin
          spec_sel[p] <= (rd_idx[p] == IDX_W'(IDX_SP)) || (rd_idx[p] == IDX_W'(IDX_PC));
          spec_q[p]   <= (rd_idx[p] == IDX_W'(IDX_SP)) ? sp_cur : pc_q;
        end
      end
      assign rd_data[p] = spec_sel[p] ? spec_q[p] : ram_q[p];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      t_q     <= 1'b0;
      fault_q <= 1'b0;
    end else if (ld_pc) begin
      pc_q    <= {ld_word[DATA_W-1:1], 1'b0};
      t_q     <= ld_word[0];
      fault_q <= ~ld_word[0];
    end else if (pc_we) begin
      pc_q    <= {wr_data[DATA_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= 1'b0;
      ctrl_q  <= 2'b00;
    end else if (ready) begin
      if (flags_wr) flags_q <= flags_in;
      if (mask_wr)  mask_q  <= mask_in[0];
      if (ctrl_wr)  ctrl_q  <= ctrl_in[1:0];
    end
  end

  always_comb begin
    psr_out = '0;
    psr_out[PSR_F_LSB +: FLAG_W] = flags_q;
    psr_out[PSR_T_POS]           = t_q;
    psr_out[EXC_W-1:0]           = exc_num;
  end

  assign mask_out   = DATA_W'(mask_q);
  assign ctrl_out   = DATA_W'(ctrl_q);
  assign core_ready = ready;
  assign vec_fault  = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst) vec_fault |=> vec_fault); // R4
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (rst) pc_q[0] == 1'b0); // R7
  AST_T_FROM_ENTRY: assert property (@(posedge clk) disable iff (rst) ld_pc |=> (psr_out[PSR_T_POS] == $past(ld_word[0]))); // R3
  AST_BOOT_NO_WRITES: assert property (@(posedge clk) disable iff (rst) !core_ready |=> ($stable(mask_out) && $stable(ctrl_out))); // R10
endmodule

// File: tb/tb_core_regbank.sv
`timescale 1ns/1ps
module tb_core_regbank;
  logic        clk = 1'b0, rst = 1'b1;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        core_ready, vec_fault;
  logic [5:0]  exc_num = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, flags_wr = 1'b0, mask_wr = 1'b0, ctrl_wr = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] psr_out, mask_in = '0, mask_out, ctrl_in = '0, ctrl_out;
  logic [31:0] boot_sp, boot_vec;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  core_regbank dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .core_ready(core_ready),
    .vec_fault(vec_fault), .exc_num(exc_num), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .flags_wr(flags_wr), .flags_in(flags_in), .psr_out(psr_out),
    .mask_wr(mask_wr), .mask_in(mask_in), .mask_out(mask_out), .ctrl_wr(ctrl_wr),
    .ctrl_in(ctrl_in), .ctrl_out(ctrl_out)
  );

  // Memory responder: one-cycle latency.
  always @(posedge clk) begin
    mem_rvalid <= !rst && mem_req;
    mem_rdata  <= (mem_addr == 32'h4) ? boot_vec : boot_sp;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_reg[16];
  bit          m_v[16];
  logic [31:0] m_msp, m_psp, m_pc, e_a, e_b;
  bit          m_t, m_fault, m_pm, v_a, v_b, m_on;
  logic [3:0]  m_flags;
  logic [1:0]  m_ctl;
  int          m_phase;

  function automatic bit m_psp_sel();
    return (exc_num == 0) && m_ctl[1];
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a == 13) return m_psp_sel() ? m_psp : m_msp;
    if (a == 15) return m_pc;
    return m_reg[a];
  endfunction

  function automatic bit m_valid(input logic [3:0] a);
    return (a == 13) || (a == 15) || m_v[a];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_msp = 0; m_psp = 0; m_pc = 0; m_t = 0; m_fault = 0;
      m_flags = 0; m_pm = 0; m_ctl = 0; v_a = 0; v_b = 0; m_on = 1;
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end else begin
      e_a = m_read(rd_a_idx); v_a = m_valid(rd_a_idx);
      e_b = m_read(rd_b_idx); v_b = m_valid(rd_b_idx);
      if (m_phase == 4) begin
        if (wr_en) begin
          if (wr_idx == 13) begin
            if (m_psp_sel()) m_psp = wr_data & 32'hFFFF_FFFC;
            else m_msp = wr_data & 32'hFFFF_FFFC;
          end else if (wr_idx == 15) m_pc = wr_data & 32'hFFFF_FFFE;
          else begin m_reg[wr_idx] = wr_data; m_v[wr_idx] = 1; end
        end
        if (flags_wr) m_flags = flags_in;
        if (mask_wr) m_pm = mask_in[0];
        if (ctrl_wr) m_ctl = ctrl_in[1:0];
      end
      case (m_phase)
        0: m_phase = 1;
        1: if (mem_rvalid) begin m_msp = mem_rdata & 32'hFFFF_FFFC; m_phase = 2; end
        2: m_phase = 3;
        3: if (mem_rvalid) begin
             m_pc = mem_rdata & 32'hFFFF_FFFE; m_t = mem_rdata[0];
             m_fault = !mem_rdata[0]; m_phase = 4;
           end
        default: ;
      endcase
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_on && !rst) begin
      chk("R1 core_ready", {31'b0, core_ready}, {31'b0, m_phase == 4});
      chk("R1 mem_req", {31'b0, mem_req}, {31'b0, m_phase == 0 || m_phase == 2});
      if (m_phase == 0 || m_phase == 2)
        chk("R1 mem_addr", mem_addr, (m_phase == 2) ? 32'h4 : 32'h0);
      chk("R4 vec_fault", {31'b0, vec_fault}, {31'b0, m_fault});
      if (v_a) chk("R5 port A", rd_a_data, e_a);
      if (v_b) chk("R5 port B", rd_b_data, e_b);
      chk("R8 psr", psr_out, {m_flags, 3'b0, m_t, 18'b0, exc_num});
      chk("R9 mask", mask_out, {31'b0, m_pm});
      chk("R9 ctrl", ctrl_out, {30'b0, m_ctl});
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_idx = a; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    rd_a_idx = a; @(posedge clk); @(negedge clk);
    chk(req, rd_a_data, exp); #1;
  endtask

  task automatic boot(input logic [31:0] sp, input logic [31:0] vec);
    int n;
    boot_sp = sp; boot_vec = vec; rst = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1 ready low in reset", {31'b0, core_ready}, 32'd0);
    chk("R9 mask reset", mask_out, 32'd0);
    chk("R9 ctrl reset", ctrl_out, 32'd0);
    chk("R4 fault reset", {31'b0, vec_fault}, 32'd0);
    // hold writes through boot; R10 says they must be ignored
    wr_en = 1; wr_idx = 13; wr_data = 32'hDEAD_BEE0;
    mask_wr = 1; mask_in = 32'h1; ctrl_wr = 1; ctrl_in = 32'h2;
    flags_wr = 1; flags_in = 4'hF;
    rst = 0; n = 0;
    while (!core_ready && n < 20) begin cyc(); n++; end
    wr_en = 0; mask_wr = 0; ctrl_wr = 0; flags_wr = 0;
    chk("R1 boot cycles", n, 4);
    chk("R10 mask untouched", mask_out, 32'd0);
    chk("R10 ctrl untouched", ctrl_out, 32'd0);
    chk("R10 flags untouched", {28'b0, psr_out[31:28]}, 32'd0);
  endtask

  initial begin
    boot(32'h2000_1003, 32'h0000_0101);
    rd(13, 32'h2000_1000, "R2 main sp from word 0");
    rd(15, 32'h0000_0100, "R3 pc from word 1");
    chk("R3 T bit", {31'b0, psr_out[24]}, 32'd1);
    chk("R4 no fault", {31'b0, vec_fault}, 32'd0);

    for (int i = 0; i < 13; i++) wr(i[3:0], 32'h1111_0000 + i * 32'h0101);
    for (int i = 0; i < 13; i++) rd(i[3:0], 32'h1111_0000 + i * 32'h0101, "R5 gpr");
    rd_b_idx = 4'd7;
    rd(3, 32'h1111_0303, "R5 port A with B busy");
    chk("R5 port B", rd_b_data, 32'h1111_0707);

    // read-old on same-cycle write
    rd_a_idx = 5; wr_en = 1; wr_idx = 5; wr_data = 32'hCAFE_F00D;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk); chk("R5 read before write", rd_a_data, 32'h1111_0505); #1;
    rd(5, 32'hCAFE_F00D, "R5 new value");
    wr(14, 32'hABCD_0001);
    rd(14, 32'hABCD_0001, "R5 link reg");

    ctrl_wr = 1; ctrl_in = 32'h2; cyc(); ctrl_wr = 0;
    wr(13, 32'h3000_0007);
    rd(13, 32'h3000_0004, "R7 psp aligned");
    exc_num = 6'd3;
    rd(13, 32'h2000_1000, "R6 handler uses main");
    exc_num = 6'd0;
    ctrl_wr = 1; ctrl_in = 32'h0; cyc(); ctrl_wr = 0;
    rd(13, 32'h2000_1000, "R6 thread main");
    ctrl_wr = 1; ctrl_in = 32'h2; cyc(); ctrl_wr = 0;
    rd(13, 32'h3000_0004, "R6 thread process");
    exc_num = 6'd9;
    wr(13, 32'h2000_0F02);
    exc_num = 6'd0;
    rd(13, 32'h3000_0004, "R6 process kept");
    exc_num = 6'd9;
    rd(13, 32'h2000_0F00, "R7 main aligned");
    exc_num = 6'd0;

    wr(15, 32'h0000_1235);
    rd(15, 32'h0000_1234, "R7 pc even");

    flags_wr = 1; flags_in = 4'hA; cyc(); flags_wr = 0;
    exc_num = 6'h2A;
    @(negedge clk); chk("R8 psr layout", psr_out, 32'hA100_002A); #1;
    exc_num = 6'd0;

    mask_wr = 1; mask_in = 32'hFFFF_FFFF; cyc(); mask_wr = 0;
    @(negedge clk); chk("R9 mask bit0 only", mask_out, 32'h1); #1;
    ctrl_wr = 1; ctrl_in = 32'hFFFF_FFFD; cyc(); ctrl_wr = 0;
    @(negedge clk); chk("R9 ctrl bits 1:0 only", ctrl_out, 32'h1); #1;

    boot(32'h1000_0000, 32'h0000_0200);
    chk("R4 fault on even vector", {31'b0, vec_fault}, 32'd1);
    chk("R3 T bit clear", {31'b0, psr_out[24]}, 32'd0);
    rd(15, 32'h0000_0200, "R3 pc second boot");
    repeat (3) cyc();
    chk("R4 fault sticky", {31'b0, vec_fault}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule